// File: doc/BRIEF.md
# Output RGB to YUV Color Matrix

This block sits at the output of a display compositor. It turns each 24-bit RGB pixel into a 24-bit YUV pixel. Every output channel is a weighted sum of the three input channels plus a constant. The weights and constants come from twelve programmable coefficient registers. A global enable selects between the matrix result and the unchanged input pixel. Both paths have the same fixed latency, so switching modes never reorders or drops pixels.

Software programs the coefficients and the enable through a single-cycle register-write port. Pixels enter and leave on valid-qualified streams, with no back-pressure. The coefficients and the enable in force when a pixel is accepted travel with that pixel. Writes made while pixels are in flight therefore never mix old and new settings within one pixel.

Top module: `yuv_out_matrix`

## Requirements
- R1: After reset `out_vld` is 0 and `out_pix` is 0. The matrix is disabled (bypass) and every coefficient holds its default value from R7.
- R2: A pixel accepted with `in_vld`=1 in cycle n appears with `out_vld`=1 in cycle n+3. `out_vld` is 0 in every cycle whose cycle n-3 had `in_vld`=0, and back-to-back pixels stay back-to-back.
- R3: While the enable bit is 0, `out_pix` equals the accepted `in_pix` bit for bit, with the latency of R2.
- R4: Pixel layout is R in [23:16], G in [15:8] and B in [7:0]; the output is Y in [23:16], U in [15:8] and V in [7:0]. Each output channel k is `m0*R + m1*G + m2*B + off`, using the coefficients of row k.
- R5: Each multiplier is 14-bit two's complement with 10 fractional bits, and each offset is 14-bit two's complement with 4 fractional bits. The exact sum is rounded half up to an integer (offset 0x008 gives 1, 0x007 gives 0, 0x3FF8 gives 0, 0x018 gives 2).
- R6: The rounded result saturates to 0 when negative and to 255 when above 255.
- R7: The default coefficients are as follows. Y row: 0x107, 0x204, 0x064, offset 0x108. U row: 0x3F69, 0x3ED6, 0x1C1, offset 0x808. V row: 0x1C1, 0x3E88, 0x3FB8, offset 0x808. With these defaults black maps to 0x118181, white to 0xEB8181, red to 0x525BF0, green to 0x913623 and blue to 0x29F06F.
- R8: A write with `cfg_wr`=1 stores `cfg_data[13:0]` in coefficient `cfg_addr` for addresses 0 to 11, where address = 4*row + column, columns 0 to 2 are the R, G and B multipliers, column 3 is the offset, and rows 0, 1 and 2 are Y, U and V. Address 12 stores `cfg_data[0]` as the enable.
- R9: Writes to addresses 13 to 31 change no coefficient and do not change the enable.
- R10: A pixel accepted in the same cycle as a write uses the settings from before the write. Pixels accepted later use the new settings, and pixels already in flight keep the settings from their own accept cycle.
- R11: `out_pix` holds its last value in every cycle where `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_data | input | 14 | Register write data |
| in_vld | input | 1 | Input pixel valid |
| in_pix | input | 24 | Input RGB pixel |
| out_vld | output | 1 | Output pixel valid |
| out_pix | output | 24 | Output YUV (or bypassed) pixel |

## Verification
The two functions that can collide are a register write and the acceptance of a pixel in the same cycle. This happens most sharply when the enable is toggled, or an offset or multiplier is rewritten, while a gapped pixel stream is running. The bench drives a continuous stream with idle gaps and issues writes to the enable, a luma offset and a chroma multiplier on chosen stream cycles. For each pixel it predicts the result from the settings in force before that cycle's write. Every output is judged against that prediction, so a design that applies a write one cycle early, or that lets a pixel in flight pick up a new offset or enable, is caught at the exact pixel.

// File: rtl/yuv_mat_pkg.sv
package yuv_mat_pkg;
  localparam int PIX_W      = 8;
  localparam int NCH        = 3;
  localparam int COEF_W     = 14;
  localparam int MUL_FRAC   = 10;
  localparam int OFF_FRAC   = 4;
  localparam int ROW_TERMS  = NCH + 1;
  localparam int NCOEF      = NCH * ROW_TERMS;
  localparam int ADDR_W     = 5;

  // Power-up coefficient set, indexed 4*row + column.
  function automatic logic [COEF_W-1:0] coef_default(input int idx);
    logic [COEF_W-1:0] v;
    case (idx)
      0:  v = 14'h0107;
      1:  v = 14'h0204;
      2:  v = 14'h0064;
      3:  v = 14'h0108;
      4:  v = 14'h3f69;
      5:  v = 14'h3ed6;
      6:  v = 14'h01c1;
      7:  v = 14'h0808;
      8:  v = 14'h01c1;
      9:  v = 14'h3e88;
      10: v = 14'h3fb8;
      11: v = 14'h0808;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/yuv_coef_regs.sv
module yuv_coef_regs
  import yuv_mat_pkg::*;
#(
  parameter int P_COEF_W = COEF_W,
  parameter int P_NCOEF  = NCOEF,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [P_ADDR_W-1:0]               wr_addr,
  input  logic [P_COEF_W-1:0]               wr_data,
  output logic [P_NCOEF-1:0][P_COEF_W-1:0]  coef_o,
  output logic                              en_o
);
  localparam logic [P_ADDR_W-1:0] CTRL_ADDR = P_ADDR_W'(P_NCOEF);

  logic [P_NCOEF-1:0][P_COEF_W-1:0] coef_q, coef_d;
  logic                             en_q, en_d;

  always_comb begin
    coef_d = coef_q;
    en_d   = en_q;
    for (int i = 0; i < P_NCOEF; i++) begin
      if (wr_addr == P_ADDR_W'(i)) coef_d[i] = wr_data;
    end
    if (wr_addr == CTRL_ADDR) en_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < P_NCOEF; i++) coef_q[i] <= P_COEF_W'(coef_default(i));
      en_q <= 1'b0;
    end else if (wr_en) begin
      coef_q <= coef_d;
      en_q   <= en_d;
    end
  end

  assign coef_o = coef_q;
  assign en_o   = en_q;

  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > CTRL_ADDR) |=> ($stable(coef_q) && $stable(en_q))); // R9
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_ADDR) |=> (en_q == $past(wr_data[0]))); // R8
endmodule

// File: rtl/yuv_mat_row.sv
module yuv_mat_row
  import yuv_mat_pkg::*;
#(
  parameter int P_PIX_W    = PIX_W,
  parameter int P_NIN      = NCH,
  parameter int P_COEF_W   = COEF_W,
  parameter int P_MUL_FRAC = MUL_FRAC,
  parameter int P_OFF_FRAC = OFF_FRAC
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ce_s1,
  input  logic                             ce_s2,
  input  logic [P_NIN-1:0][P_PIX_W-1:0]    pix_i,
  input  logic [P_NIN-1:0][P_COEF_W-1:0]   mul_i,
  input  logic [P_COEF_W-1:0]              off_i,
  output logic [P_PIX_W-1:0]               res_o
);
  localparam int PROD_W  = P_COEF_W + P_PIX_W + 1;
  localparam int SUM_W   = PROD_W + $clog2(P_NIN) + 1;
  localparam int OFF_SH  = P_MUL_FRAC - P_OFF_FRAC;
  localparam int OFF_EXT = SUM_W - P_COEF_W - OFF_SH;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (P_MUL_FRAC - 1);

  logic [P_NIN-1:0][PROD_W-1:0] prod_d, prod_q;
  logic [P_COEF_W-1:0]          off_q;
  logic [SUM_W-1:0]             sum_d, sum_q, rnd;
  logic                         unused_frac;

  for (genvar t = 0; t < P_NIN; t++) begin : g_term
    logic signed [PROD_W-1:0] m_ext, p_ext;
    assign m_ext     = {{(PROD_W-P_COEF_W){mul_i[t][P_COEF_W-1]}}, mul_i[t]};
    assign p_ext     = {{(PROD_W-P_PIX_W){1'b0}}, pix_i[t]};
    assign prod_d[t] = m_ext * p_ext;
  end

  always_comb begin
    sum_d = {{OFF_EXT{off_q[P_COEF_W-1]}}, off_q, {OFF_SH{1'b0}}};
    for (int t = 0; t < P_NIN; t++) begin
      sum_d = sum_d + {{(SUM_W-PROD_W){prod_q[t][PROD_W-1]}}, prod_q[t]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      off_q  <= '0;
    end else if (ce_s1) begin
      prod_q <= prod_d;
      off_q  <= off_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum_q <= '0;
    else if (ce_s2) sum_q <= sum_d;
  end

  assign rnd         = sum_q + HALF;
  assign unused_frac = ^rnd[P_MUL_FRAC-1:0];

  always_comb begin
    if (rnd[SUM_W-1])
      res_o = '0;
    else if (|rnd[SUM_W-2:P_MUL_FRAC+P_PIX_W])
      res_o = '1;
    else
      res_o = rnd[P_MUL_FRAC+P_PIX_W-1:P_MUL_FRAC];
  end
endmodule

// File: rtl/yuv_out_matrix.sv
module yuv_out_matrix
  import yuv_mat_pkg::*;
#(
  parameter int P_PIX_W    = PIX_W,
  parameter int P_NCH      = NCH,
  parameter int P_COEF_W   = COEF_W,
  parameter int P_MUL_FRAC = MUL_FRAC,
  parameter int P_OFF_FRAC = OFF_FRAC,
  parameter int P_ADDR_W   = ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [P_ADDR_W-1:0]         cfg_addr,
  input  logic [P_COEF_W-1:0]         cfg_data,
  input  logic                        in_vld,
  input  logic [P_NCH*P_PIX_W-1:0]    in_pix,
  output logic                        out_vld,
  output logic [P_NCH*P_PIX_W-1:0]    out_pix
);
  localparam int TERMS = P_NCH + 1;
  localparam int NC    = P_NCH * TERMS;
  localparam int BUS_W = P_NCH * P_PIX_W;

  logic [NC-1:0][P_COEF_W-1:0]    coef_w;
  logic                           cfg_en;
  logic [P_NCH-1:0][P_PIX_W-1:0]  in_ch;
  logic [BUS_W-1:0]               mat_res;

  logic             vld_s1, vld_s2, en_s1, en_s2;
  logic [BUS_W-1:0] pix_s1, pix_s2, out_d;

  yuv_coef_regs #(
    .P_COEF_W (P_COEF_W),
    .P_NCOEF  (NC),
    .P_ADDR_W (P_ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .coef_o  (coef_w),
    .en_o    (cfg_en)
  );

  for (genvar t = 0; t < P_NCH; t++) begin : g_in
    assign in_ch[t] = in_pix[BUS_W-1-t*P_PIX_W -: P_PIX_W];
  end

  for (genvar c = 0; c < P_NCH; c++) begin : g_row
    logic [P_NCH-1:0][P_COEF_W-1:0] mul_c;
    for (genvar t = 0; t < P_NCH; t++) begin : g_mul
      assign mul_c[t] = coef_w[c*TERMS+t];
    end
    yuv_mat_row #(
      .P_PIX_W    (P_PIX_W),
      .P_NIN      (P_NCH),
      .P_COEF_W   (P_COEF_W),
      .P_MUL_FRAC (P_MUL_FRAC),
      .P_OFF_FRAC (P_OFF_FRAC)
    ) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_s1 (in_vld),
      .ce_s2 (vld_s1),
      .pix_i (in_ch),
      .mul_i (mul_c),
      .off_i (coef_w[c*TERMS+P_NCH]),
      .res_o (mat_res[BUS_W-1-c*P_PIX_W -: P_PIX_W])
    );
  end

  always_comb begin
    out_d = en_s2 ? mat_res : pix_s2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s1  <= 1'b0;
      vld_s2  <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      vld_s1  <= in_vld;
      vld_s2  <= vld_s1;
      out_vld <= vld_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s1 <= '0;
      en_s1  <= 1'b0;
    end else if (in_vld) begin
      pix_s1 <= in_pix;
      en_s1  <= cfg_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s2 <= '0;
      en_s2  <= 1'b0;
    end else if (vld_s1) begin
      pix_s2 <= pix_s1;
      en_s2  <= en_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_pix <= '0;
    else if (vld_s2) out_pix <= out_d;
  end

  // Cycles since reset, so three-deep history is only read once it exists.
  logic [1:0] ast_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ast_age <= 2'd0;
    else if (ast_age != 2'd3) ast_age <= ast_age + 2'd1;
  end

  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (ast_age == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R2
  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (ast_age == 2'd3 && out_vld && !$past(cfg_en, 3)) |-> (out_pix == $past(in_pix, 3))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_s2 |=> $stable(out_pix)); // R11
endmodule

// File: tb/sim_yuv_out_matrix.sv
`timescale 1ns/1ps
module sim_yuv_out_matrix;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [4:0]  cfg_addr;
  logic [13:0] cfg_data;
  logic        in_vld;
  logic [23:0] in_pix;
  logic        out_vld;
  logic [23:0] out_pix;

  always #2.5 clk = ~clk;

  yuv_out_matrix u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_vld(in_vld), .in_pix(in_pix),
    .out_vld(out_vld), .out_pix(out_pix)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int mc [12];
  bit men;

  // {enable, pixel, expected}: R3 bypass entries first, then R7 defaults.
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 24'h123456, 24'h123456},
    {1'b0, 24'hff0080, 24'hff0080},
    {1'b0, 24'h000000, 24'h000000},
    {1'b1, 24'h000000, 24'h118181},
    {1'b1, 24'hffffff, 24'heb8181},
    {1'b1, 24'hff0000, 24'h525bf0},
    {1'b1, 24'h00ff00, 24'h913623},
    {1'b1, 24'h0000ff, 24'h29f06f}
  };

  function automatic int dflt(input int i);
    case (i)
      0: return 'h107;  1: return 'h204;  2: return 'h064;  3: return 'h108;
      4: return 'h3f69; 5: return 'h3ed6; 6: return 'h1c1;  7: return 'h808;
      8: return 'h1c1;  9: return 'h3e88; 10: return 'h3fb8; default: return 'h808;
    endcase
  endfunction

  function automatic int sx14(input int v);
    return (v >= 8192) ? v - 16384 : v;
  endfunction

  // R4/R5/R6 reference: signed fixed point, round half up, clamp.
  function automatic logic [23:0] model(input logic [23:0] p);
    logic [23:0] r;
    if (!men) return p;
    for (int row = 0; row < 3; row++) begin
      int acc;
      acc = 0;
      for (int t = 0; t < 3; t++) acc += sx14(mc[4*row+t]) * int'(p[23-8*t -: 8]);
      acc += sx14(mc[4*row+3]) * 64 + 512;
      acc = acc >>> 10;
      if (acc < 0) acc = 0;
      if (acc > 255) acc = 255;
      r[23-8*row -: 8] = 8'(acc);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_data = '0;
    in_vld = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) mc[i] = dflt(i);
    men = 1'b0;
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_data = 14'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a < 12) mc[a] = d & 'h3fff;
    else if (a == 12) men = d[0];
  endtask

  task automatic one_pix(input logic [23:0] p, output logic [23:0] got);
    @(negedge clk);
    in_vld = 1'b1; in_pix = p;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    chk("R2 idle gap", 24'(out_vld), 24'h0);
    @(negedge clk);
    chk("R2 valid after 3", 24'(out_vld), 24'h1);
    got = out_pix;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  logic [23:0] got;
  logic [23:0] se [64];
  bit          sv [64];

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 reset out_vld", 24'(out_vld), 24'h0);
    chk("R1 reset out_pix", out_pix, 24'h0);

    // Table walk: first entries also show R1 (bypass after reset).
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][48] != men) cfg_write(12, int'(VEC[i][48]));
      one_pix(VEC[i][47:24], got);
      chk(VEC[i][48] ? "R7 default matrix" : "R1/R3 bypass", got, VEC[i][23:0]);
    end

    // R5 rounding on the Y row with zero multipliers.
    cfg_write(0, 0); cfg_write(1, 0); cfg_write(2, 0);
    cfg_write(3, 'h008); one_pix(24'hffffff, got); chk("R5 +0.5 rounds up", 24'(got[23:16]), 24'd1);
    cfg_write(3, 'h007); one_pix(24'hffffff, got); chk("R5 0.4375 rounds down", 24'(got[23:16]), 24'd0);
    cfg_write(3, 'h3ff8); one_pix(24'hffffff, got); chk("R5 -0.5 rounds to 0", 24'(got[23:16]), 24'd0);
    cfg_write(3, 'h018); one_pix(24'h000000, got); chk("R5 1.5 rounds to 2", 24'(got[23:16]), 24'd2);

    // R6 saturation at both ends.
    cfg_write(3, 'h1fff); one_pix(24'h000000, got); chk("R6 clamp high offset", 24'(got[23:16]), 24'd255);
    cfg_write(3, 'h2000); one_pix(24'hffffff, got); chk("R6 clamp low offset", 24'(got[23:16]), 24'd0);
    cfg_write(3, 0); cfg_write(0, 'h1fff);
    one_pix(24'hff0000, got); chk("R6 clamp high multiplier", 24'(got[23:16]), 24'd255);
    chk("R4 full pixel vs model", got, model(24'hff0000));

    // R8: address 6 is the U row B multiplier.
    cfg_write(6, 0);
    one_pix(24'h0000ff, got); chk("R8 addr 6 U blue term", 24'(got[15:8]), 24'h81);

    // R9: out-of-range writes leave coefficients and enable alone.
    cfg_write(13, 0); cfg_write(20, 'h3fff); cfg_write(31, 0);
    one_pix(24'h4080c0, got); chk("R9 ignored writes", got, model(24'h4080c0));
    chk("R9 enable still set", 24'(men), 24'h1);

    // R10/R11/R2: gapped stream with writes landing on pixel cycles.
    do_reset();
    begin
      logic [23:0] last;
      last = 24'h0;
      for (int k = 0; k < 51; k++) begin
        @(negedge clk);
        if (k >= 3) begin
          chk("R2 stream valid", 24'(out_vld), 24'(sv[k-3]));
          if (sv[k-3]) chk("R10 stream pixel", out_pix, se[k-3]);
          else         chk("R11 hold when idle", out_pix, last);
          last = out_pix;
        end
        cfg_wr = 1'b0;
        in_vld = 1'b0;
        if (k < 48) begin
          logic [31:0] pk;
          pk = (32'(k) * 32'h0009e377) ^ 32'h00a5c3f1;
          sv[k] = (k % 5) != 2;
          in_vld = sv[k];
          in_pix = pk[23:0];
          se[k] = model(pk[23:0]);
          if (k == 8)  begin cfg_wr = 1'b1; cfg_addr = 5'd12; cfg_data = 14'h1;    men = 1'b1; end
          if (k == 20) begin cfg_wr = 1'b1; cfg_addr = 5'd3;  cfg_data = 14'h1fff; mc[3] = 'h1fff; end
          if (k == 21) begin cfg_wr = 1'b1; cfg_addr = 5'd4;  cfg_data = 14'h2000; mc[4] = 'h2000; end
          if (k == 30) begin cfg_wr = 1'b1; cfg_addr = 5'd12; cfg_data = 14'h0;    men = 1'b0; end
        end
      end
    end

    // R1: reset restores defaults after reprogramming.
    cfg_write(0, 0); cfg_write(12, 1);
    do_reset();
    one_pix(24'h00ff00, got); chk("R1 bypass after reset", got, 24'h00ff00);
    cfg_write(12, 1);
    one_pix(24'hffffff, got); chk("R1 defaults restored", got, 24'heb8181);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule